// File: doc/BRIEF.md
# Timer Register Bridge Between System and Oscillator Clock Domains

This block lets a host on the system clock program and read an 8-bit timer/counter. The counter itself can run from the system clock or from a separate slow oscillator clock. A clock-select bit picks between them. The host writes the count, compare and control values into holding registers on the system side. In asynchronous mode, each holding register is carried into the timer domain by its own toggle handshake. Each of the three registers has its own busy bit, which software polls before it writes that register again.

The timer domain raises an overflow event when the count wraps and a compare event when the count steps onto the compare value. Both events are carried back to the system clock and stored as flags. Software clears a flag by writing a one to it. Each flag drives an interrupt output through its own enable bit and a global enable input.

A write to a register whose transfer is still in flight is dropped, and a one-cycle protocol-error pulse reports it. After the clock-select bit changes, software is expected to rewrite the count, compare and control registers.

Top module: `tmr_xdom_bridge`

## Requirements
- R1: After reset, every readable register returns zero, and `irq_cmp`, `irq_ovf` and `proto_err` are low.
- R2: The addresses are 0 count, 1 compare, 2 control, 3 status, 4 mask and 5 flags. Control bit 0 is the run bit. Status bit 3 is the clock select (1 selects the oscillator), bit 2 is count busy, bit 1 is compare busy and bit 0 is control busy. Mask bit 1 enables the compare interrupt and bit 0 enables the overflow interrupt. Flags bit 1 is the compare flag and bit 0 is the overflow flag. All other bits read as zero.
- R3: With clock select at 0, a write to count, compare or control takes effect at the system clock edge that samples it. The busy bits stay 0, and back-to-back writes raise no `proto_err`.
- R4: With clock select at 1, an accepted write to count, compare or control sets that register's busy bit, and the bit is visible right after the write edge.
- R5: A busy bit clears by itself once the value has reached the timer domain. From then on, the timer register holds the written value.
- R6: In asynchronous mode, a write to a register whose busy bit is set is dropped, leaving the holding value unchanged. `proto_err` is high for exactly the one cycle after that write edge.
- R7: A read of the count returns the live timer value. A read of compare or control returns the holding register.
- R8: While the run bit is 1, the count rises by one on each timer clock edge. While the run bit is 0, the count holds.
- R9: The overflow flag sets when the count wraps from 255 to 0.
- R10: The compare flag sets when the count steps to a value equal to the compare register. Loading the count directly does not set it.
- R11: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R12: `irq_cmp` is high exactly when the compare flag, compare enable and `gie` are all 1. `irq_ovf` is high exactly when the overflow flag, overflow enable and `gie` are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock for the host side |
| clk_osc | input | 1 | Slow oscillator clock used as the timer clock when selected |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, sampled on `clk_sys` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| gie | input | 1 | Global interrupt enable |
| irq_cmp | output | 1 | Compare-match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| proto_err | output | 1 | Pulse when a write hits a busy register |

## Verification
The hardest case to reach is a second write that lands inside the busy window of an asynchronous transfer. The value must be dropped and reported, while the first value still completes. The bench runs the oscillator about seven times slower than the system clock, so a transfer spans tens of system cycles. It then issues back-to-back writes to the same register, both directed and at random. After each transfer completes, it reads back the holding copy or the live count. The compare path across domains is also driven end to end: the count and compare values are loaded through the handshake, the timer is started, and the bench waits for the flag to come back.

// File: rtl/tmr_bridge_pkg.sv
package tmr_bridge_pkg;
   // host register addresses
   localparam int ADR_CNT  = 0;
   localparam int ADR_CMP  = 1;
   localparam int ADR_CTL  = 2;
   localparam int ADR_STAT = 3;
   localparam int ADR_MASK = 4;
   localparam int ADR_FLAG = 5;
   // staged channels; channel index equals its address
   localparam int CH_CNT = 0;
   localparam int CH_CMP = 1;
   localparam int CH_CTL = 2;
   localparam int NCH    = 3;
   // event / flag bit positions
   localparam int EV_OVF = 0;
   localparam int EV_CMP = 1;
   localparam int NEV    = 2;
endpackage

// File: rtl/tmr_sync_chain.sv
module tmr_sync_chain #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tmr_xfer_chan.sv
module tmr_xfer_chan #(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk_sys,
   input  logic          clk_tmr,
   input  logic          rst_n,
   input  logic          async_mode,
   input  logic          wr_stb,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] hold_o,
   output logic          busy_o,
   output logic          viol_o,
   output logic          ld_o,
   output logic [DW-1:0] ld_data_o
);
   logic [DW-1:0] hold_q;
   logic          busy_q, req_q, ack_q, req_s, ack_s;
   logic          accept, ld_async;

   assign accept = wr_stb & ~busy_q;
   assign viol_o = wr_stb & busy_q;

   // system side: holding register, request toggle, busy
   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         busy_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         if (accept) hold_q <= wdata;
         if (accept && async_mode) begin
            req_q  <= ~req_q;
            busy_q <= 1'b1;
         end else if (busy_q && (ack_s == req_q)) begin
            busy_q <= 1'b0;
         end
      end
   end

   tmr_sync_chain #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
      .clk(clk_tmr), .rst_n(rst_n), .d(req_q), .q(req_s));

   // timer side: acknowledge follows the synchronized request
   always_ff @(posedge clk_tmr or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= req_s;
   end

   assign ld_async = req_s ^ ack_q;

   tmr_sync_chain #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
      .clk(clk_sys), .rst_n(rst_n), .d(ack_q), .q(ack_s));

   assign hold_o    = hold_q;
   assign busy_o    = busy_q;
   assign ld_o      = ld_async | (~async_mode & accept);
   assign ld_data_o = ld_async ? hold_q : wdata;

   // R3
   sync_no_busy_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
      !async_mode |=> !$rose(busy_q));
   // R6
   hold_stable_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
      busy_q |=> $stable(hold_q));
   // R4
   req_busy_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
      !$stable(req_q) |-> (busy_q && !$past(busy_q)));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int DW = 8
) (
   input  logic          clk_tmr,
   input  logic          rst_n,
   input  logic          ld_cnt,
   input  logic [DW-1:0] cnt_d,
   input  logic          ld_cmp,
   input  logic [DW-1:0] cmp_d,
   input  logic          ld_ctl,
   input  logic [DW-1:0] ctl_d,
   output logic [DW-1:0] cnt_o,
   output logic          ovf_tgl_o,
   output logic          cmp_tgl_o
);
   localparam logic [DW-1:0] CNT_TOP = '1;

   logic [DW-1:0] cnt_q, cmp_q, ctl_q, cnt_nx;
   logic          ovf_tgl_q, cmp_tgl_q, run;

   assign run    = ctl_q[0];
   assign cnt_nx = cnt_q + DW'(1);

   always_ff @(posedge clk_tmr or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         cmp_q     <= '0;
         ctl_q     <= '0;
         ovf_tgl_q <= 1'b0;
         cmp_tgl_q <= 1'b0;
      end else begin
         if (ld_cnt)   cnt_q <= cnt_d;
         else if (run) cnt_q <= cnt_nx;
         if (ld_cmp) cmp_q <= cmp_d;
         if (ld_ctl) ctl_q <= ctl_d;
         if (!ld_cnt && run) begin
            if (cnt_q == CNT_TOP) ovf_tgl_q <= ~ovf_tgl_q;
            if (cnt_nx == cmp_q)  cmp_tgl_q <= ~cmp_tgl_q;
         end
      end
   end

   assign cnt_o     = cnt_q;
   assign ovf_tgl_o = ovf_tgl_q;
   assign cmp_tgl_o = cmp_tgl_q;

   // R9
   ovf_evt_chk: assert property (@(posedge clk_tmr) disable iff (!rst_n)
      !$stable(ovf_tgl_q) |-> (cnt_q == '0));
   // R10
   cmp_evt_chk: assert property (@(posedge clk_tmr) disable iff (!rst_n)
      !$stable(cmp_tgl_q) |-> (cnt_q == $past(cmp_q)));
   // R5
   ctl_load_chk: assert property (@(posedge clk_tmr) disable iff (!rst_n)
      ld_ctl |=> (ctl_q == $past(ctl_d)));
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
   parameter int NEV         = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk_sys,
   input  logic           rst_n,
   input  logic [NEV-1:0] evt_tgl,
   input  logic [NEV-1:0] clr,
   input  logic [NEV-1:0] en,
   input  logic           gie,
   output logic [NEV-1:0] flag_o,
   output logic [NEV-1:0] irq_o
);
   logic [NEV-1:0] tgl_s, tgl_last, ev, flag_q;

   tmr_sync_chain #(.STAGES(SYNC_STAGES), .W(NEV)) u_evt_sync (
      .clk(clk_sys), .rst_n(rst_n), .d(evt_tgl), .q(tgl_s));

   assign ev = tgl_s ^ tgl_last;

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         tgl_last <= '0;
         flag_q   <= '0;
      end else begin
         tgl_last <= tgl_s;
         flag_q   <= ev | (flag_q & ~clr);
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & en & {NEV{gie}};

   for (genvar i = 0; i < NEV; i++) begin : g_flag_chk
      // R11
      flag_clr_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
         (clr[i] && !ev[i]) |=> !flag_q[i]);
   end
endmodule

// File: rtl/tmr_xdom_bridge.sv
module tmr_xdom_bridge
   import tmr_bridge_pkg::*;
#(
   parameter int DW          = 8,
   parameter int AW          = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk_sys,
   input  logic          clk_osc,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          gie,
   output logic          irq_cmp,
   output logic          irq_ovf,
   output logic          proto_err
);
   generate
      if (DW < 4) begin : g_bad_dw
         $error("tmr_xdom_bridge: DW must be at least 4");
      end
      if (AW < 3) begin : g_bad_aw
         $error("tmr_xdom_bridge: AW must be at least 3");
      end
   endgenerate

   logic                 sel_q, perr_q, clk_tmr;
   logic [NEV-1:0]       mask_q, flags, irqs, clr, evt_tgl;
   logic [NCH-1:0]       wr_stb, busy, viol, ld;
   logic [DW-1:0]        hold    [NCH];
   logic [DW-1:0]        ld_data [NCH];
   logic [DW-1:0]        cnt_live;

   assign clk_tmr = sel_q ? clk_osc : clk_sys;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign wr_stb[c] = wr_en && (addr == AW'(c));
      tmr_xfer_chan #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk_sys    (clk_sys),
         .clk_tmr    (clk_tmr),
         .rst_n      (rst_n),
         .async_mode (sel_q),
         .wr_stb     (wr_stb[c]),
         .wdata      (wdata),
         .hold_o     (hold[c]),
         .busy_o     (busy[c]),
         .viol_o     (viol[c]),
         .ld_o       (ld[c]),
         .ld_data_o  (ld_data[c])
      );
   end

   tmr_count_core #(.DW(DW)) u_core (
      .clk_tmr   (clk_tmr),
      .rst_n     (rst_n),
      .ld_cnt    (ld[CH_CNT]),
      .cnt_d     (ld_data[CH_CNT]),
      .ld_cmp    (ld[CH_CMP]),
      .cmp_d     (ld_data[CH_CMP]),
      .ld_ctl    (ld[CH_CTL]),
      .ctl_d     (ld_data[CH_CTL]),
      .cnt_o     (cnt_live),
      .ovf_tgl_o (evt_tgl[EV_OVF]),
      .cmp_tgl_o (evt_tgl[EV_CMP])
   );

   assign clr = (wr_en && (addr == AW'(ADR_FLAG))) ? wdata[NEV-1:0] : '0;

   tmr_evt_flags #(.NEV(NEV), .SYNC_STAGES(SYNC_STAGES)) u_flags (
      .clk_sys (clk_sys),
      .rst_n   (rst_n),
      .evt_tgl (evt_tgl),
      .clr     (clr),
      .en      (mask_q),
      .gie     (gie),
      .flag_o  (flags),
      .irq_o   (irqs)
   );

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         mask_q <= '0;
         perr_q <= 1'b0;
      end else begin
         perr_q <= |viol;
         if (wr_en && (addr == AW'(ADR_STAT))) sel_q  <= wdata[3];
         if (wr_en && (addr == AW'(ADR_MASK))) mask_q <= wdata[NEV-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(ADR_CNT):  rdata = cnt_live;
         AW'(ADR_CMP):  rdata = hold[CH_CMP];
         AW'(ADR_CTL):  rdata = hold[CH_CTL];
         AW'(ADR_STAT): rdata[3:0] = {sel_q, busy[CH_CNT], busy[CH_CMP], busy[CH_CTL]};
         AW'(ADR_MASK): rdata[NEV-1:0] = mask_q;
         AW'(ADR_FLAG): rdata[NEV-1:0] = flags;
         default:       rdata = '0;
      endcase
   end

   assign irq_ovf   = irqs[EV_OVF];
   assign irq_cmp   = irqs[EV_CMP];
   assign proto_err = perr_q;

   // R6
   perr_src_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
      proto_err |-> $past(wr_en));
endmodule

// File: tb/sim_tmr_xdom_bridge.sv
module sim_tmr_xdom_bridge;
   localparam int CLK_P = 10;
   localparam int OSC_P = 74;
   localparam logic [2:0] A_CNT = 3'd0, A_CMP = 3'd1, A_CTL = 3'd2,
                          A_STAT = 3'd3, A_MASK = 3'd4, A_FLAG = 3'd5;

   logic       clk_sys = 1'b0, clk_osc = 1'b0, rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0, gie = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq_cmp, irq_ovf, proto_err;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk_sys = ~clk_sys;
   always #(OSC_P/2) clk_osc = ~clk_osc;

   tmr_xdom_bridge u0 (
      .clk_sys(clk_sys), .clk_osc(clk_osc), .rst_n(rst_n), .addr(addr),
      .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .gie(gie),
      .irq_cmp(irq_cmp), .irq_ovf(irq_ovf), .proto_err(proto_err));

   function automatic logic [7:0] exp_status(logic s, logic bc, logic bm, logic bt);
      return {4'b0000, s, bc, bm, bt};
   endfunction

   function automatic logic exp_irq(logic f, logic e, logic g);
      return f & e & g;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk_sys);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk_sys);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic wait_idle(string req);
      logic [7:0] v;
      for (int k = 0; k < 400; k++) begin
         rd(A_STAT, v);
         if (v[2:0] == 3'b000) break;
         @(negedge clk_sys);
      end
      chk(req, v[2:0], 3'b000);
   endtask

   task automatic poll_flag(int bi, int lim, string req);
      logic [7:0] v;
      for (int k = 0; k < lim; k++) begin
         rd(A_FLAG, v);
         if (v[bi]) break;
         @(negedge clk_sys);
      end
      chk(req, v[bi], 1'b1);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, a0, b0;
      logic [2:0] ra;
      logic [7:0] rv;
      int unsigned seed;
      seed = $urandom(32'd20240);

      repeat (3) @(negedge clk_sys);
      rst_n = 1'b1;
      @(negedge clk_sys);
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         chk("R1 reset register", v, 8'h00);
      end
      chk("R1 reset irq_cmp", irq_cmp, 1'b0);
      chk("R1 reset irq_ovf", irq_ovf, 1'b0);
      chk("R1 reset proto_err", proto_err, 1'b0);

      // synchronous mode
      wr(A_CMP, 8'h5A);
      rd(A_CMP, v);  chk("R3 compare written", v, 8'h5A);
      rd(A_STAT, v); chk("R3 no busy", v, exp_status(0, 0, 0, 0));
      wr(A_CNT, 8'h33);
      rd(A_CNT, v);  chk("R3 count written", v, 8'h33);
      wr(A_CTL, 8'h01);
      rd(A_CTL, v);  chk("R7 control holding", v, 8'h01);
      rd(A_CNT, v);  chk("R8 count at start", v, 8'h33);
      repeat (7) @(posedge clk_sys);
      @(negedge clk_sys);
      rd(A_CNT, v);  chk("R8 count after 7 edges", v, 8'h3A);
      wr(A_CTL, 8'h00);
      rd(A_CNT, a0);
      repeat (5) @(negedge clk_sys);
      rd(A_CNT, b0); chk("R8 count holds when stopped", b0, a0);

      // overflow
      gie = 1'b1;
      wr(A_MASK, 8'h03);
      rd(A_MASK, v); chk("R2 mask readback", v, 8'h03);
      wr(A_CNT, 8'hFC);
      wr(A_FLAG, 8'h03);
      wr(A_CTL, 8'h01);
      poll_flag(0, 40, "R9 overflow flag");
      chk("R12 irq_ovf asserted", irq_ovf, exp_irq(1, 1, 1));
      rd(A_FLAG, v); chk("R10 no early compare", v[1], 1'b0);
      chk("R12 irq_cmp idle", irq_cmp, 1'b0);
      gie = 1'b0; #1;
      chk("R12 gie low", irq_ovf, exp_irq(1, 1, 0));
      gie = 1'b1;
      wr(A_MASK, 8'h02);
      chk("R12 mask low", irq_ovf, exp_irq(1, 0, 1));
      wr(A_FLAG, 8'h00);
      rd(A_FLAG, v); chk("R11 zero write keeps flag", v[0], 1'b1);
      wr(A_FLAG, 8'h01);
      rd(A_FLAG, v); chk("R11 one write clears", v[0], 1'b0);
      wr(A_CTL, 8'h00);

      // compare match, synchronous
      wr(A_CNT, 8'h08);
      wr(A_CMP, 8'h10);
      wr(A_FLAG, 8'h03);
      rd(A_FLAG, v); chk("R10 count load sets no flag", v, 8'h00);
      wr(A_CTL, 8'h01);
      poll_flag(1, 40, "R10 compare flag");
      chk("R12 irq_cmp asserted", irq_cmp, exp_irq(1, 1, 1));
      rd(A_FLAG, v); chk("R9 no wrap yet", v[0], 1'b0);
      wr(A_CTL, 8'h00);

      // asynchronous mode
      wr(A_STAT, 8'h08);
      rd(A_STAT, v); chk("R2 clock select bit", v, exp_status(1, 0, 0, 0));
      wr(A_CTL, 8'h00);
      rd(A_STAT, v); chk("R4 control busy", v, exp_status(1, 0, 0, 1));
      wait_idle("R5 control busy clears");
      wr(A_CMP, 8'hA5);
      rd(A_STAT, v); chk("R4 compare busy", v, exp_status(1, 0, 1, 0));
      rd(A_CMP, v);  chk("R7 compare holding", v, 8'hA5);
      wr(A_CMP, 8'h11);
      chk("R6 proto_err pulse", proto_err, 1'b1);
      rd(A_CMP, v);  chk("R6 write dropped", v, 8'hA5);
      @(negedge clk_sys);
      chk("R6 pulse one cycle", proto_err, 1'b0);
      wait_idle("R5 compare busy clears");
      wr(A_CNT, 8'h20);
      rd(A_STAT, v); chk("R4 count busy", v, exp_status(1, 1, 0, 0));
      wait_idle("R5 count busy clears");
      rd(A_CNT, v);  chk("R5 count transferred", v, 8'h20);
      wr(A_CMP, 8'h24);
      wait_idle("R5 compare idle");
      wr(A_FLAG, 8'h03);
      wr(A_MASK, 8'h02);
      wr(A_CTL, 8'h01);
      wait_idle("R5 control idle");
      poll_flag(1, 400, "R10 async compare flag");
      chk("R12 async irq_cmp", irq_cmp, exp_irq(1, 1, 1));
      rd(A_CNT, a0);
      repeat (60) @(negedge clk_sys);
      rd(A_CNT, b0);
      chk("R8 live count moves", (a0 != b0), 1'b1);
      wr(A_CTL, 8'h00);
      wait_idle("R5 stop idle");

      // random asynchronous transfers
      for (int i = 0; i < 24; i++) begin
         ra = ($urandom % 2 == 0) ? A_CNT : A_CMP;
         rv = 8'($urandom);
         wr(ra, rv);
         if (ra == A_CMP) begin
            rd(A_CMP, v); chk("R7 random holding", v, rv);
         end
         if ($urandom % 3 == 0) begin
            wr(ra, ~rv);
            chk("R6 random violation", proto_err, 1'b1);
         end
         wait_idle("R5 random busy clears");
         rd(ra, v);
         chk("R5 random value kept", v, rv);
      end

      // random synchronous writes
      wr(A_STAT, 8'h00);
      wr(A_CTL, 8'h00);
      for (int i = 0; i < 16; i++) begin
         ra = ($urandom % 2 == 0) ? A_CNT : A_CMP;
         rv = 8'($urandom);
         wr(ra, rv);
         wr(ra, rv);
         chk("R3 no proto_err in sync", proto_err, 1'b0);
         rd(ra, v);     chk("R3 random immediate", v, rv);
         rd(A_STAT, v); chk("R3 random no busy", v, exp_status(0, 0, 0, 0));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule